// File: doc/BRIEF.md
# Dual-Bank Configurable MAC Filter Array

This block is the arithmetic core of a sample-rate filter engine. It holds twenty-one multiply-accumulate stages arranged as three sections of seven, each section built in transposed form. Each section has its own 8-bit tap input. If the same sample stream feeds all three inputs, the core works as a single 21-tap FIR filter. If three line-delayed streams feed the inputs, it works as a 3-row by 7-column two-dimensional window. The sum leaving one section passes through a single pipeline register and becomes the starting accumulator value of the next section. The head of the first section takes a 22-bit cascade operand, which is tied to zero when it is not used.

Coefficients are kept in two banks. One bank drives the multipliers and the other bank can be rewritten through a plain address/data/strobe port, without stalling the sample flow. A bank-select input picks the working bank. An optional alternating mode exchanges the two banks after every accepted sample. Data and coefficients each have their own signed/unsigned selection. All products and sums are kept at full precision and the result is a 22-bit two's complement word.

Top module: `dual_bank_mac_array`

## Requirements
- R1: While reset is asserted, and up to the first accepted sample after reset, `result` is zero and every stored coefficient is zero.
- R2: Let sample n be the n-th clock edge with `sample_en` high. Let x_s be the byte `tap_in[8s+7:8s]` for section s (0..2), and c[s][j] the coefficient of stage j (0..6). After sample n, `result` equals the sum over s and j of x_s(n-(6-j)-8*(2-s)) * c[s][j], plus `casc_in` of sample n-22. Samples before reset count as zero.
- R3: Each section multiplies only its own tap byte, so different bytes on the three lanes give a two-dimensional window sum.
- R4: When `data_signed` is 1, tap bytes are read as two's complement. When it is 0, they are read as unsigned 0..255.
- R5: When `coef_signed` is 1, coefficients are read as two's complement. When it is 0, they are read as unsigned. This selection is independent of R4.
- R6: When `auto_swap` is 0, each sample is multiplied with the bank named by `bank_sel` in that same cycle. A change of `bank_sel` takes effect on the next sample with no lost sample.
- R7: When `auto_swap` is 1, the working bank alternates on every accepted sample. The first sample after `auto_swap` rises uses `bank_sel`. Dropping `auto_swap` returns to `bank_sel`.
- R8: The write address is `cw_addr[5]` = bank, `cw_addr[4:3]` = section, `cw_addr[2:0]` = stage. A write with section 3 or stage 7 changes nothing.
- R9: A write to the working bank in a cycle with `sample_en` high is dropped. A write to the other bank is always taken, and so is any write in a cycle with `sample_en` low. A taken write first affects the next sample.
- R10: In a cycle with `sample_en` low, `result` and the pipeline do not move.
- R11: `casc_in` enters the head accumulator and reaches `result` 22 samples later, unscaled.
- R12: No truncation or rounding takes place. 21 products of 255 x 255 give exactly 1,365,525, and mixed-sign products are exact. Results wrap modulo 2^22.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sample_en | input | 1 | Accept one sample and advance the pipeline |
| tap_in | input | 24 | Three tap bytes; section s uses bits [8s+7:8s] |
| data_signed | input | 1 | 1: tap bytes are two's complement |
| coef_signed | input | 1 | 1: coefficients are two's complement |
| bank_sel | input | 1 | Working coefficient bank (starting bank in alternating mode) |
| auto_swap | input | 1 | Alternate banks on every sample |
| casc_in | input | 22 | Head accumulator operand |
| cw_en | input | 1 | Coefficient write strobe |
| cw_addr | input | 6 | {bank, section[1:0], stage[2:0]} |
| cw_data | input | 8 | Coefficient value |
| result | output | 22 | Full-precision two's complement sum |

## Verification
The bench compares every output against a convolution model that it keeps itself. This exposes a missing or doubled inter-section register, which would shift the whole upper sections by one sample, and a cascade operand that arrives on the wrong sample. Format tests drive bytes such as 0x80 and 0xFF under each signedness setting. A wrong extension bit there turns -128 into 128 or 255 into -1. The bench toggles banks in the middle of a stream and runs the alternating mode, so a bank change applied one sample late, or an alternation that skips or repeats, produces a wrong output. Illegal addresses and writes to the working bank during streaming are exercised as well. A decoder that aliases stage 7 into the next section, or that lets a locked write through, corrupts later outputs.

// File: rtl/mac_pkg.sv
package mac_pkg;
  localparam int DATA_W = 8;
  localparam int COEF_W = 8;
  localparam int ACC_W  = 22;
  localparam int N_SEC  = 3;
  localparam int N_STG  = 7;
  localparam int SEC_AW = 2;
  localparam int STG_AW = 3;
  localparam int ADDR_W = 1 + SEC_AW + STG_AW;
  localparam int N_TAP  = N_SEC * N_STG;
endpackage

// File: rtl/bank_seq.sv
module bank_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_en,
  input  logic bank_sel,
  input  logic auto_swap,
  output logic active_bank
);
  logic phase_q;
  logic phase_d;

  always_comb begin
    phase_d = phase_q;
    if (!auto_swap)
      phase_d = 1'b0;
    else if (sample_en)
      phase_d = ~phase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      phase_q <= 1'b0;
    else
      phase_q <= phase_d;
  end

  assign active_bank = bank_sel ^ (auto_swap & phase_q);
endmodule

// File: rtl/coef_store.sv
module coef_store #(
  parameter int NS  = mac_pkg::N_SEC,
  parameter int NT  = mac_pkg::N_STG,
  parameter int CW  = mac_pkg::COEF_W,
  parameter int SAW = mac_pkg::SEC_AW,
  parameter int TAW = mac_pkg::STG_AW
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   busy,
  input  logic                   active_bank,
  input  logic                   wr_en,
  input  logic                   wr_bank,
  input  logic [SAW-1:0]         wr_sec,
  input  logic [TAW-1:0]         wr_stg,
  input  logic [CW-1:0]          wr_data,
  output logic [NS*NT*CW-1:0]    coef_act,
  output logic [2*NS*NT*CW-1:0]  mem_view
);
  localparam int NTAP  = NS * NT;
  localparam int IDX_W = $clog2(NTAP);

  logic [1:0][NTAP-1:0][CW-1:0] mem_q;
  logic [1:0][NTAP-1:0][CW-1:0] mem_d;
  logic                         sec_ok;
  logic                         stg_ok;
  logic                         bank_free;
  logic                         wr_ok;
  logic [IDX_W-1:0]             idx;

  assign sec_ok    = {1'b0, wr_sec} < (SAW+1)'(NS);
  assign stg_ok    = {1'b0, wr_stg} < (TAW+1)'(NT);
  assign bank_free = (wr_bank != active_bank) || !busy;
  assign wr_ok     = wr_en && sec_ok && stg_ok && bank_free;
  assign idx       = IDX_W'(wr_sec) * IDX_W'(NT) + IDX_W'(wr_stg);

  always_comb begin
    mem_d = mem_q;
    if (wr_ok)
      mem_d[wr_bank][idx] = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      mem_q <= '0;
    else if (wr_ok)
      mem_q <= mem_d;
  end

  assign coef_act = mem_q[active_bank];
  assign mem_view = mem_q;
endmodule

// File: rtl/mac_section.sv
module mac_section #(
  parameter int STAGES = mac_pkg::N_STG,
  parameter int DW     = mac_pkg::DATA_W,
  parameter int CW     = mac_pkg::COEF_W,
  parameter int AW     = mac_pkg::ACC_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic [DW-1:0]        x_in,
  input  logic                 x_signed,
  input  logic                 c_signed,
  input  logic [STAGES*CW-1:0] coefs,
  input  logic [AW-1:0]        acc_in,
  output logic [AW-1:0]        acc_out
);
  localparam int PW = DW + CW + 2;

  logic signed [DW:0] x_ext;
  assign x_ext = signed'({x_signed & x_in[DW-1], x_in});

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic signed [CW:0]   c_ext;
    logic signed [PW-1:0] prod;
    logic [AW-1:0]        prev;
    logic [AW-1:0]        acc_d;
    logic [AW-1:0]        acc_q;

    assign c_ext = signed'({c_signed & coefs[g*CW+CW-1], coefs[g*CW +: CW]});
    assign prod  = x_ext * c_ext;

    if (g == 0) begin : g_head
      assign prev = acc_in;
    end else begin : g_link
      assign prev = g_stage[g-1].acc_q;
    end

    always_comb acc_d = prev + {{(AW-PW){prod[PW-1]}}, prod};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        acc_q <= '0;
      else if (en)
        acc_q <= acc_d;
    end
  end

  assign acc_out = g_stage[STAGES-1].acc_q;
endmodule

// File: rtl/dual_bank_mac_array.sv
module dual_bank_mac_array #(
  parameter int DW   = mac_pkg::DATA_W,
  parameter int CW   = mac_pkg::COEF_W,
  parameter int AW   = mac_pkg::ACC_W,
  parameter int NS   = mac_pkg::N_SEC,
  parameter int NT   = mac_pkg::N_STG,
  parameter int SAW  = mac_pkg::SEC_AW,
  parameter int TAW  = mac_pkg::STG_AW
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sample_en,
  input  logic [NS*DW-1:0]       tap_in,
  input  logic                   data_signed,
  input  logic                   coef_signed,
  input  logic                   bank_sel,
  input  logic                   auto_swap,
  input  logic [AW-1:0]          casc_in,
  input  logic                   cw_en,
  input  logic [SAW+TAW:0]       cw_addr,
  input  logic [CW-1:0]          cw_data,
  output logic [AW-1:0]          result
);
  localparam int BANK_BIT = SAW + TAW;
  localparam int SEC_BITS = NT * CW;

  logic [1:0]            rst_pipe_q;
  logic                  rst_sync_n;
  logic                  active_bank;
  logic [NS*NT*CW-1:0]   coef_act;
  logic [2*NS*NT*CW-1:0] store_view;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_pipe_q <= '0;
    else
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  bank_seq u_bank (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .sample_en   (sample_en),
    .bank_sel    (bank_sel),
    .auto_swap   (auto_swap),
    .active_bank (active_bank)
  );

  coef_store #(.NS(NS), .NT(NT), .CW(CW), .SAW(SAW), .TAW(TAW)) u_store (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .busy        (sample_en),
    .active_bank (active_bank),
    .wr_en       (cw_en),
    .wr_bank     (cw_addr[BANK_BIT]),
    .wr_sec      (cw_addr[TAW +: SAW]),
    .wr_stg      (cw_addr[0 +: TAW]),
    .wr_data     (cw_data),
    .coef_act    (coef_act),
    .mem_view    (store_view)
  );

  for (genvar s = 0; s < NS; s++) begin : g_sec
    logic [AW-1:0] chain_in;
    logic [AW-1:0] chain_out;

    if (s == 0) begin : g_first
      assign chain_in = casc_in;
    end else begin : g_next
      assign chain_in = g_sec[s-1].g_hold.hold_q;
    end

    mac_section #(.STAGES(NT), .DW(DW), .CW(CW), .AW(AW)) u_sec (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .en       (sample_en),
      .x_in     (tap_in[s*DW +: DW]),
      .x_signed (data_signed),
      .c_signed (coef_signed),
      .coefs    (coef_act[s*SEC_BITS +: SEC_BITS]),
      .acc_in   (chain_in),
      .acc_out  (chain_out)
    );

    if (s < NS - 1) begin : g_hold
      logic [AW-1:0] hold_q;
      always_ff @(posedge clk or negedge rst_sync_n) begin
        if (!rst_sync_n)
          hold_q <= '0;
        else if (sample_en)
          hold_q <= chain_out;
      end
    end
  end

  assign result = g_sec[NS-1].chain_out;
endmodule

// File: rtl/mac_array_chk.sv
module mac_array_chk
  import mac_pkg::*;
(
  input logic                      clk,
  input logic                      rst_n,
  input logic                      sample_en,
  input logic                      bank_sel,
  input logic                      auto_swap,
  input logic                      active_bank,
  input logic                      cw_en,
  input logic [ADDR_W-1:0]         cw_addr,
  input logic [ACC_W-1:0]          result,
  input logic [2*N_TAP*COEF_W-1:0] store
);
  localparam int BANK_BIT = SEC_AW + STG_AW;

  // R1
  always @(posedge clk) begin
    if (!rst_n)
      reset_clear_chk: assert (result == '0 && store == '0);
  end

  // R10
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_en |=> $stable(result));

  // R7
  swap_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && auto_swap) ##1 (auto_swap && $stable(bank_sel))
      |-> active_bank != $past(active_bank));

  // R9
  locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cw_en && sample_en && cw_addr[BANK_BIT] == active_bank) |=> $stable(store));

  // R8
  bad_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cw_en && (cw_addr[STG_AW +: SEC_AW] == 2'd3 || cw_addr[0 +: STG_AW] == 3'd7))
      |=> $stable(store));
endmodule

bind dual_bank_mac_array mac_array_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .sample_en   (sample_en),
  .bank_sel    (bank_sel),
  .auto_swap   (auto_swap),
  .active_bank (active_bank),
  .cw_en       (cw_en),
  .cw_addr     (cw_addr),
  .result      (result),
  .store       (store_view)
);

// File: tb/sim_dual_bank_mac_array.sv
module sim_dual_bank_mac_array;
  import mac_pkg::*;

  localparam int HIST = 32;
  localparam logic [23:0] STIM [24] = '{
    24'h010203, 24'hFF0000, 24'h00FF00, 24'h0000FF, 24'h807F01, 24'h7F8080,
    24'hFFFFFF, 24'h000000, 24'h123456, 24'hABCDEF, 24'h55AA55, 24'hAA55AA,
    24'h0F0F0F, 24'hF0F0F0, 24'h800000, 24'h000080, 24'h010000, 24'h000001,
    24'h7E7E7E, 24'h818181, 24'h3C5A96, 24'hC3A569, 24'h020406, 24'hFEDCBA
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_n;
  logic              sample_en;
  logic [23:0]       tap_in;
  logic              data_signed;
  logic              coef_signed;
  logic              bank_sel;
  logic              auto_swap;
  logic [ACC_W-1:0]  casc_in;
  logic              cw_en;
  logic [ADDR_W-1:0] cw_addr;
  logic [7:0]        cw_data;
  logic [ACC_W-1:0]  result;

  dual_bank_mac_array u0 (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .tap_in(tap_in),
    .data_signed(data_signed), .coef_signed(coef_signed), .bank_sel(bank_sel),
    .auto_swap(auto_swap), .casc_in(casc_in), .cw_en(cw_en), .cw_addr(cw_addr),
    .cw_data(cw_data), .result(result)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int n;
  bit ph;
  int hp [HIST][N_SEC][N_STG];
  int hc [HIST];
  logic [7:0] coefm [2][N_SEC][N_STG];

  task automatic chk(string req, logic [ACC_W-1:0] act, logic [ACC_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int to_val(logic [7:0] v, logic sgn);
    return sgn ? int'($signed(v)) : int'(v);
  endfunction

  function automatic logic [ACC_W-1:0] model(int m);
    int sum = 0;
    for (int s = 0; s < N_SEC; s++)
      for (int j = 0; j < N_STG; j++) begin
        int k = m - (N_STG - 1 - j) - (N_STG + 1) * (N_SEC - 1 - s);
        if (k >= 0) sum += hp[k % HIST][s][j];
      end
    if (m - 22 >= 0) sum += hc[(m - 22) % HIST];
    return ACC_W'(sum);
  endfunction

  // one clock: drive at negedge, update model at edge, compare at next negedge
  task automatic cycle(string req, bit en, logic [23:0] taps, logic [ACC_W-1:0] casc,
                       bit wr, logic [ADDR_W-1:0] addr, logic [7:0] wd);
    logic [ACC_W-1:0] prev;
    bit ab;
    sample_en = en; tap_in = taps; casc_in = casc;
    cw_en = wr; cw_addr = addr; cw_data = wd;
    prev = result;
    @(posedge clk);
    ab = bank_sel ^ (auto_swap & ph);
    if (en) begin
      for (int s = 0; s < N_SEC; s++)
        for (int j = 0; j < N_STG; j++)
          hp[n % HIST][s][j] = to_val(taps[s*8 +: 8], data_signed) *
                               to_val(coefm[ab][s][j], coef_signed);
      hc[n % HIST] = int'($signed(casc));
      n++;
    end
    if (wr && addr[4:3] != 2'd3 && addr[2:0] != 3'd7 && (addr[5] != ab || !en))
      coefm[addr[5]][addr[4:3]][addr[2:0]] = wd;
    if (!auto_swap) ph = 0;
    else if (en) ph = ~ph;
    @(negedge clk);
    cw_en = 1'b0;
    if (en) chk(req, result, model(n - 1));
    else    chk(req, result, prev);
  endtask

  task automatic stream(string req, int cnt);
    for (int i = 0; i < cnt; i++) cycle(req, 1'b1, STIM[i % 24], '0, 1'b0, '0, '0);
  endtask

  task automatic wr_idle(string req, bit b, int s, int j, logic [7:0] v);
    cycle(req, 1'b0, 24'h0, '0, 1'b1, {b, 2'(s), 3'(j)}, v);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; sample_en = 0; tap_in = '0; casc_in = '0; cw_en = 0;
    cw_addr = '0; cw_data = '0; data_signed = 0; coef_signed = 0;
    bank_sel = 0; auto_swap = 0;
    n = 0; ph = 0;
    for (int k = 0; k < HIST; k++) begin
      hc[k] = 0;
      for (int s = 0; s < N_SEC; s++)
        for (int j = 0; j < N_STG; j++) hp[k][s][j] = 0;
    end
    for (int b = 0; b < 2; b++)
      for (int s = 0; s < N_SEC; s++)
        for (int j = 0; j < N_STG; j++) coefm[b][s][j] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk("R1 reset result", result, '0);
    stream("R1 zero coefficients after reset", 4);

    // load both banks while idle; output must hold
    for (int s = 0; s < N_SEC; s++)
      for (int j = 0; j < N_STG; j++) begin
        wr_idle("R10 idle write", 1'b0, s, j, 8'(s * 7 + j + 1));
        wr_idle("R10 idle write", 1'b1, s, j, 8'((j - 3) * (s + 1) * 9));
      end
    wr_idle("R5 load 0x80", 1'b1, 2, 6, 8'h80);

    stream("R2 R3 table walk", 30);
    data_signed = 1;
    stream("R4 signed data", 30);
    data_signed = 0; coef_signed = 1; bank_sel = 1;
    stream("R5 signed coefficients", 30);
    data_signed = 1;
    stream("R4 R5 both signed", 30);
    data_signed = 0; coef_signed = 0;

    // cascade operand latency
    for (int i = 0; i < 26; i++) cycle("R11 flush", 1'b1, 24'h0, '0, 1'b0, '0, '0);
    cycle("R11 cascade", 1'b1, 24'h0, 22'h12345, 1'b0, '0, '0);
    for (int i = 1; i <= 24; i++) begin
      cycle("R11 cascade", 1'b1, 24'h0, '0, 1'b0, '0, '0);
      if (i == 22) chk("R11 cascade arrives", result, 22'h12345);
    end
    for (int i = 0; i < 30; i++)
      cycle("R11 cascade stream", 1'b1, STIM[i % 24], ACC_W'(i * 1000 - 7000), 1'b0, '0, '0);

    // mid-stream bank changes
    coef_signed = 1;
    for (int i = 0; i < 32; i++) begin
      bank_sel = (i / 4) % 2 == 1;
      cycle("R6 bank toggle", 1'b1, STIM[(i * 5) % 24], '0, 1'b0, '0, '0);
    end
    bank_sel = 0; auto_swap = 1;
    stream("R7 alternating banks", 31);
    auto_swap = 0;
    stream("R7 alternation off", 25);
    bank_sel = 1; auto_swap = 1;
    stream("R7 alternating from bank 1", 25);
    auto_swap = 0; bank_sel = 0; coef_signed = 0;

    // write locking
    cycle("R9 locked write", 1'b1, STIM[3], '0, 1'b1, {1'b0, 2'd1, 3'd3}, 8'hC8);
    stream("R9 after locked write", 25);
    cycle("R9 write idle bank", 1'b1, STIM[5], '0, 1'b1, {1'b1, 2'd0, 3'd2}, 8'h33);
    bank_sel = 1;
    stream("R9 idle-bank write used", 25);
    wr_idle("R9 idle write active bank", 1'b1, 2, 0, 8'h44);
    stream("R9 idle write used", 25);

    // illegal addresses
    wr_idle("R8 section 3", 1'b1, 3, 1, 8'h55);
    wr_idle("R8 stage 7", 1'b1, 0, 7, 8'h66);
    wr_idle("R8 stage 7", 1'b0, 1, 7, 8'h77);
    stream("R8 bank1 unchanged", 25);
    bank_sel = 0;
    stream("R8 bank0 unchanged", 25);

    // freeze with changing inputs
    for (int i = 0; i < 8; i++)
      cycle("R10 freeze", 1'b0, STIM[i], ACC_W'(i * 77), 1'b0, '0, '0);

    // full precision extremes
    for (int s = 0; s < N_SEC; s++)
      for (int j = 0; j < N_STG; j++) wr_idle("R12 load", 1'b0, s, j, 8'hFF);
    for (int i = 0; i < 30; i++) cycle("R12 max", 1'b1, 24'hFFFFFF, '0, 1'b0, '0, '0);
    chk("R12 max sum", result, 22'd1365525);
    coef_signed = 1;
    for (int i = 0; i < 30; i++) cycle("R12 mixed", 1'b1, 24'hFFFFFF, '0, 1'b0, '0, '0);
    chk("R12 mixed sum", result, ACC_W'(-5355));
    data_signed = 1;
    for (int i = 0; i < 30; i++) cycle("R12 signed", 1'b1, 24'h808080, '0, 1'b0, '0, '0);
    chk("R12 signed sum", result, ACC_W'(2688));

    // reset in the middle of activity
    do_reset();
    chk("R1 reset mid-run", result, '0);
    stream("R1 coefficients cleared", 10);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule